// File: doc/BRIEF.md
# Serial LED Driver Logic Core

This block is the digital part of a multi-channel output driver that is loaded over a serial link. A bit stream on `ser_in` is clocked into a shift register by rising edges of `shift_clk`. The oldest bit of that register leaves on `ser_out`, so several drivers can be chained into one long stream. A level-sensitive load strobe copies the register into an output latch. An active-low output enable blanks every channel at once. The result is a vector of channel-on signals, one per output, where 1 means the channel conducts.

The core runs on a fast system clock `clk` and oversamples the serial-side pins. Each of the four control inputs passes through a synchronizer of `SYNC_STAGES` flops. Edges of `shift_clk` are then detected in the system clock domain. The level latch is built as an equivalent system-clock register. While the strobe is high it takes the next shift-register value in the same cycle, so it tracks the register with no extra delay. While the strobe is low it keeps its value. No real latch cell is inferred.

Top module: `serial_led_drv`

## Requirements
- R1: Asserting `rst_n` low clears the shift register and the output latch asynchronously, so `chan_on` is all zeros and `ser_out` is 0 until new data arrives.
- R2: Each rising edge of `shift_clk` moves the register by one place toward the last stage and puts the `ser_in` value into stage 0. A falling edge of `shift_clk`, or a steady `shift_clk` level, leaves the register unchanged.
- R3: After eight rising edges with the latch open, the first bit shifted in drives `chan_on[7]` and the most recent bit drives `chan_on[0]`.
- R4: `ser_out` always equals the last stage of the register, which is the bit captured seven rising edges before the latest one.
- R5: While `load_strobe` is high the latch is transparent. Every shift made during the high period reaches `chan_on` without any further strobe edge.
- R6: While `load_strobe` is low the latch holds its value, and shifting does not change `chan_on`.
- R7: When `out_en_n` is 1, every bit of `chan_on` is 0 whatever the latch holds. When `out_en_n` is 0, each `chan_on` bit equals its latched bit, and a latched 1 means the channel is on.
- R8: With the default `SYNC_STAGES` = 2, a new shift result appears on `chan_on` or `ser_out` at the third rising edge of `clk` after the `shift_clk` rise, and not before. A change of `out_en_n` reaches `chan_on` at the second rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Serial data into stage 0 |
| shift_clk | input | 1 | Shift clock; the rising edge shifts |
| load_strobe | input | 1 | Level strobe; high = latch transparent |
| out_en_n | input | 1 | Active-low output enable; high blanks all channels |
| ser_out | output | 1 | Last register stage, for cascading |
| chan_on | output | CHANNELS | Channel-on vector, 1 = on |

## Verification
The bench loads several bytes: 0xA5 and 0x3C as alternating mixes, 0xFF and 0x00 as uniform patterns, and 0x80 as a single set bit. The single-bit and asymmetric patterns show whether the bit order is right or reversed, and the uniform ones expose stuck or dropped stages. Each load is done once with the strobe low, to prove the outputs hold, and once with the strobe raised, to prove transparency. A shift made while the strobe stays high separates a level latch from an edge-triggered one. A cycle-exact probe of one shift separates the stated synchronizer latency from a shorter or longer one.

// File: rtl/ldrv_pkg.sv
package ldrv_pkg;
  // Synchronized control bundle sampled from the serial-side pins.
  typedef struct packed {
    logic sclk;
    logic sin;
    logic strobe;
    logic en_n;
  } ldrv_ctl_t;

  localparam int CTL_W = $bits(ldrv_ctl_t);

  // Reset level of the bundle: enable inactive (blanked), everything else low.
  localparam ldrv_ctl_t CTL_RST = '{sclk: 1'b0, sin: 1'b0, strobe: 1'b0, en_n: 1'b1};
endpackage

// File: rtl/ldrv_sync.sv
module ldrv_sync #(
  parameter int N      = 4,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= RST_VAL;
        else        stg[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= RST_VAL;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/ldrv_shift.sv
module ldrv_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclk_s,
  input  logic         sin_s,
  output logic         shift_evt,
  output logic [W-1:0] sr_d,
  output logic [W-1:0] sr_q
);
  logic sclk_prev;

  // Next register value for one shift step: new bit enters at stage 0.
  function automatic logic [W-1:0] step(input logic [W-1:0] cur, input logic b);
    return {cur[W-2:0], b};
  endfunction

  assign shift_evt = sclk_s & ~sclk_prev;
  assign sr_d      = shift_evt ? step(sr_q, sin_s) : sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev <= 1'b0;
      sr_q      <= '0;
    end else begin
      sclk_prev <= sclk_s;
      sr_q      <= sr_d;
    end
  end

  // R2: after a detected edge, the upper stages hold the old lower stages
  a_r2_shift_step: assert property (@(posedge clk) disable iff (!rst_n)
    $past(shift_evt) |-> (sr_q[W-1:1] == $past(sr_q[W-2:0])));

  // R2: without an edge the register does not move
  a_r2_no_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(shift_evt) |-> $stable(sr_q));
endmodule

// File: rtl/ldrv_latch.sv
module ldrv_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe_s,
  input  logic         en_n_s,
  input  logic [W-1:0] sr_d,
  input  logic [W-1:0] sr_q,
  output logic [W-1:0] lat_q,
  output logic [W-1:0] chan_on
);
  logic [W-1:0] lat_d;

  // Channel gating: active-low enable blanks every channel.
  function automatic logic [W-1:0] gate(input logic [W-1:0] v, input logic off);
    return off ? '0 : v;
  endfunction

  assign lat_d   = strobe_s ? sr_d : lat_q;
  assign chan_on = gate(lat_q, en_n_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= '0;
    else        lat_q <= lat_d;
  end

  // R5: an open latch tracks the shift register in the same cycle
  a_r5_transparent: assert property (@(posedge clk) disable iff (!rst_n)
    $past(strobe_s) |-> (lat_q == sr_q));

  // R6: a closed latch keeps its value
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(strobe_s) |-> $stable(lat_q));
endmodule

// File: rtl/serial_led_drv.sv
module serial_led_drv #(
  parameter int CHANNELS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ser_in,
  input  logic                shift_clk,
  input  logic                load_strobe,
  input  logic                out_en_n,
  output logic                ser_out,
  output logic [CHANNELS-1:0] chan_on
);
  import ldrv_pkg::*;

  ldrv_ctl_t pins_raw, pins_s;
  logic      shift_evt;
  logic [CHANNELS-1:0] sr_d, sr_q, lat_q;

  assign pins_raw = '{sclk: shift_clk, sin: ser_in, strobe: load_strobe, en_n: out_en_n};

  ldrv_sync #(.N(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_s)
  );

  ldrv_shift #(.W(CHANNELS)) u_shift (
    .clk(clk), .rst_n(rst_n), .sclk_s(pins_s.sclk), .sin_s(pins_s.sin),
    .shift_evt(shift_evt), .sr_d(sr_d), .sr_q(sr_q)
  );

  ldrv_latch #(.W(CHANNELS)) u_latch (
    .clk(clk), .rst_n(rst_n), .strobe_s(pins_s.strobe), .en_n_s(pins_s.en_n),
    .sr_d(sr_d), .sr_q(sr_q), .lat_q(lat_q), .chan_on(chan_on)
  );

  assign ser_out = sr_q[CHANNELS-1];

  // R1: while reset is held, no channel is on and the cascade output is low
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_off: assert (chan_on == '0 && ser_out == 1'b0);
    end
  end

  // R7: a channel can only be on if its latch bit is set
  a_r7_on_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
    ((chan_on & ~lat_q) == '0));
endmodule

// File: tb/sim_serial_led_drv.sv
module sim_serial_led_drv;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_in = 1'b0, shift_clk = 1'b0, load_strobe = 1'b0, out_en_n = 1'b0;
  logic ser_out;
  logic [7:0] chan_on;
  int n_run = 0, n_fail = 0;
  logic [7:0] model_sr = 8'h00;

  always #2.5 clk = ~clk;

  serial_led_drv #(.CHANNELS(8), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .shift_clk(shift_clk),
    .load_strobe(load_strobe), .out_en_n(out_en_n), .ser_out(ser_out), .chan_on(chan_on)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic shift_bit(input logic b);
    ser_in = b; shift_clk = 1'b0; tick(4);
    shift_clk = 1'b1; tick(4);
    shift_clk = 1'b0;
    model_sr = {model_sr[6:0], b};
  endtask

  task automatic shift_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) shift_bit(v[i]);
    tick(4);
  endtask

  task automatic t_reset;
    check("R1 reset chan", chan_on, 8'h00);
    check("R1 reset sout", {7'b0, ser_out}, 8'h00);
  endtask

  task automatic t_hidden_load;
    load_strobe = 1'b0; shift_byte(8'hA5);
    check("R6 closed latch", chan_on, 8'h00);
    check("R4 sout first bit", {7'b0, ser_out}, 8'h01);
  endtask

  task automatic t_strobe_open;
    load_strobe = 1'b1; tick(4);
    check("R3 R5 R7 open shows byte", chan_on, 8'hA5);
    load_strobe = 1'b0; tick(4);
  endtask

  task automatic t_transparent;
    load_strobe = 1'b1; tick(4);
    shift_bit(1'b1); tick(1);
    check("R5 shift during high strobe", chan_on, 8'h4B);
    check("R4 sout after ninth", {7'b0, ser_out}, 8'h00);
    load_strobe = 1'b0; tick(4);
  endtask

  task automatic t_hold;
    shift_bit(1'b0); tick(2);
    check("R6 hold while shifting", chan_on, 8'h4B);
    check("R4 sout seven back", {7'b0, ser_out}, {7'b0, model_sr[7]});
  endtask

  task automatic t_enable;
    out_en_n = 1'b1; tick(4);
    check("R7 blank all", chan_on, 8'h00);
    out_en_n = 1'b0; tick(4);
    check("R7 restore", chan_on, 8'h4B);
  endtask

  task automatic t_latency;
    load_strobe = 1'b1; tick(4);
    check("R5 open on 0x96", chan_on, 8'h96);
    ser_in = 1'b1; shift_clk = 1'b0; tick(4);
    shift_clk = 1'b1; tick(2);
    check("R8 not before third edge", chan_on, 8'h96);
    tick(1);
    check("R8 R2 at third edge", chan_on, 8'h2D);
    model_sr = 8'h2D;
    shift_clk = 1'b0; tick(4);
    check("R2 falling edge no shift", chan_on, 8'h2D);
    out_en_n = 1'b1; tick(1);
    check("R8 enable not at first edge", chan_on, 8'h2D);
    tick(1);
    check("R8 enable at second edge", chan_on, 8'h00);
    out_en_n = 1'b0; tick(4);
    load_strobe = 1'b0; tick(4);
  endtask

  task automatic t_pattern(input logic [7:0] v);
    shift_byte(v);
    load_strobe = 1'b1; tick(4);
    check("R3 pattern", chan_on, v);
    check("R4 pattern sout", {7'b0, ser_out}, {7'b0, v[7]});
    load_strobe = 1'b0; tick(4);
  endtask

  task automatic t_async_reset;
    load_strobe = 1'b1; tick(4);
    #1 rst_n = 1'b0; #0.5;
    check("R1 async clear chan", chan_on, 8'h00);
    check("R1 async clear sout", {7'b0, ser_out}, 8'h00);
    load_strobe = 1'b0; tick(3); rst_n = 1'b1; tick(4);
    load_strobe = 1'b1; tick(4);
    check("R1 latch cleared", chan_on, 8'h00);
    load_strobe = 1'b0; tick(4);
  endtask

  initial begin
    tick(3); rst_n = 1'b1; tick(4);
    t_reset();
    t_hidden_load();
    t_strobe_open();
    t_transparent();
    t_hold();
    t_enable();
    t_latency();
    t_pattern(8'h80);
    t_pattern(8'hFF);
    t_pattern(8'h00);
    t_pattern(8'h3C);
    t_async_reset();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule